// File: doc/BRIEF.md
# Dual-Bus Masked Match Event Counter

This block observes two parallel data buses on every clock cycle and compares each against one programmable pattern value. A care mask selects which bit positions take part in the comparison; positions whose mask bit is 0 are treated as don't care. Three saturating event counters are kept. The first counts the cycles in which bus A matches, the second counts the cycles in which bus B matches, and the third counts the cycles in which both match at once.

Software programs the block through a small register-style write port. One address holds the pattern value and one holds the care mask. A control address holds the count-enable flag and a clear strobe. The three counts are driven continuously on output ports. Typical uses are on-chip debug and traffic profiling, where a designer wants to know how often a given address or opcode pattern shows up on two buses, and how often it shows up on both together.

Top module: `dual_bus_match_counter`

## Requirements
- R1: Bus A matches when ((bus_a XOR value) AND mask) is zero. Each clock edge at which the count enable is set and bus A matches adds one to cnt_a, and the new count is visible after that edge.
- R2: Bus B is compared in the same way against the same value and mask, and its matches are counted in cnt_b.
- R3: cnt_ab adds one at each enabled edge at which bus A and bus B both match, so cnt_ab never exceeds cnt_a or cnt_b.
- R4: Bit positions with mask bit 0 are ignored. With an all-zero mask, every enabled cycle counts on all three counters whatever the bus values.
- R5: A match held for k consecutive enabled cycles adds exactly k to its counter.
- R6: While the count enable (control bit 0) is 0, all three counts hold their values whatever the bus values.
- R7: Each counter stops at 2**CNT_W-1 and does not wrap.
- R8: A control write (cfg_addr = 2) with bit 1 set clears all three counters at that edge, and the clear wins over any increment at the same edge.
- R9: Writes to the value (cfg_addr = 0), the mask (cfg_addr = 1) or the enable take effect from the next edge. The comparison at the write edge uses the old settings.
- R10: After reset all counts are 0, the enable is 0, the value is 0 and the mask is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 value, 1 mask, 2 control, 3 unused |
| cfg_wdata | input | DATA_W | Write data; for control, bit 0 is enable and bit 1 is clear |
| bus_a | input | DATA_W | First monitored bus |
| bus_b | input | DATA_W | Second monitored bus |
| cnt_a | output | CNT_W | Match count for bus A |
| cnt_b | output | CNT_W | Match count for bus B |
| cnt_ab | output | CNT_W | Count of cycles in which both buses match |

## Verification
The buses are driven with random traffic drawn from a mix of exact copies of the value, copies with only don't-care bits flipped, and unrelated words. This mix separates a correct mask from one that is ignored or inverted, and separates the joint counter from either single-bus counter. Further runs use an all-zero mask, a long held match, enable off, a run long enough to saturate, and a clear issued while a match is in progress. Another run drives a bus to the new value in the same cycle the value register is written, which exposes a comparison that uses the new setting too early.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
   typedef enum logic [1:0] {
      ADDR_VALUE = 2'd0,
      ADDR_MASK  = 2'd1,
      ADDR_CTRL  = 2'd2,
      ADDR_RSVD  = 2'd3
   } cfg_addr_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_CLR_BIT = 1;

   localparam int NUM_CNT = 3;
   localparam int IDX_A   = 0;
   localparam int IDX_B   = 1;
   localparam int IDX_AB  = 2;
endpackage

// File: rtl/mmc_cfg_regs.sv
module mmc_cfg_regs #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] value_q,
   output logic [DATA_W-1:0] mask_q,
   output logic              en_q,
   output logic              clr_pulse
);
   import mmc_pkg::*;

   cfg_addr_e sel;
   assign sel = cfg_addr_e'(cfg_addr);

   if (DATA_W < 2) begin : g_bad_width
      $error("mmc_cfg_regs: DATA_W must be at least 2");
   end

   logic wr_value, wr_mask, wr_ctrl;
   always_comb begin
      wr_value = cfg_wr && (sel == ADDR_VALUE);
      wr_mask  = cfg_wr && (sel == ADDR_MASK);
      wr_ctrl  = cfg_wr && (sel == ADDR_CTRL);
   end

   assign clr_pulse = wr_ctrl && cfg_wdata[CTRL_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
         mask_q  <= '1;
         en_q    <= 1'b0;
      end else begin
         if (wr_value) value_q <= cfg_wdata;
         if (wr_mask)  mask_q  <= cfg_wdata;
         if (wr_ctrl)  en_q    <= cfg_wdata[CTRL_EN_BIT];
      end
   end

   // R9: a write only changes the stored value after its own edge
   AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_value |=> $stable(value_q)) else $error("value changed without a write"); // R9
endmodule

// File: rtl/mmc_masked_cmp.sv
module mmc_masked_cmp #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] bus,
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] mask,
   output logic              hit
);
   logic [DATA_W-1:0] miss_bit;

   for (genvar bi = 0; bi < DATA_W; bi++) begin : g_bit
      assign miss_bit[bi] = mask[bi] & (bus[bi] ^ value[bi]);
   end

   assign hit = ~|miss_bit;
endmodule

// File: rtl/mmc_sat_counter.sv
module mmc_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 1) begin : g_bad_width
      $error("mmc_sat_counter: CNT_W must be at least 1");
   end

   logic at_max;
   assign at_max = (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (clr)           cnt <= '0;
      else if (inc && !at_max) cnt <= cnt + 1'b1;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (at_max && !clr) |=> (cnt == CNT_MAX)) else $error("counter wrapped"); // R7

   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)) else $error("counter jumped"); // R5
endmodule

// File: rtl/dual_bus_match_counter.sv
module dual_bus_match_counter #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [DATA_W-1:0] bus_a,
   input  logic [DATA_W-1:0] bus_b,
   output logic [CNT_W-1:0]  cnt_a,
   output logic [CNT_W-1:0]  cnt_b,
   output logic [CNT_W-1:0]  cnt_ab
);
   import mmc_pkg::*;

   logic [DATA_W-1:0] value_q, mask_q;
   logic              en_q, clr_pulse;
   logic              hit_a, hit_b;
   logic [NUM_CNT-1:0] inc_vec;
   logic [CNT_W-1:0]  cnt_arr [NUM_CNT];

   mmc_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .value_q(value_q), .mask_q(mask_q),
      .en_q(en_q), .clr_pulse(clr_pulse)
   );

   mmc_masked_cmp #(.DATA_W(DATA_W)) u_cmp_a (
      .bus(bus_a), .value(value_q), .mask(mask_q), .hit(hit_a)
   );

   mmc_masked_cmp #(.DATA_W(DATA_W)) u_cmp_b (
      .bus(bus_b), .value(value_q), .mask(mask_q), .hit(hit_b)
   );

   always_comb begin
      inc_vec         = '0;
      inc_vec[IDX_A]  = en_q & hit_a;
      inc_vec[IDX_B]  = en_q & hit_b;
      inc_vec[IDX_AB] = en_q & hit_a & hit_b;
   end

   for (genvar ci = 0; ci < NUM_CNT; ci++) begin : g_cnt
      mmc_sat_counter #(.CNT_W(CNT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .clr(clr_pulse),
         .inc(inc_vec[ci]), .cnt(cnt_arr[ci])
      );
   end

   assign cnt_a  = cnt_arr[IDX_A];
   assign cnt_b  = cnt_arr[IDX_B];
   assign cnt_ab = cnt_arr[IDX_AB];

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> (cnt_a == '0 && cnt_b == '0 && cnt_ab == '0)) else $error("clear missed"); // R8

   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !clr_pulse) |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_ab))) else $error("count moved while disabled"); // R6

   AST_JOINT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ab <= cnt_a) && (cnt_ab <= cnt_b)) else $error("joint count exceeds a single count"); // R3
endmodule

// File: tb/dual_bus_match_counter_tb.sv
`timescale 1ns/1ps
module dual_bus_match_counter_tb;
   localparam int DW = 8;
   localparam int CW = 6;
   localparam int MAXC = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic [DW-1:0] bus_a = '0, bus_b = '0;
   logic [CW-1:0] cnt_a, cnt_b, cnt_ab;

   always #2 clk = ~clk;

   dual_bus_match_counter #(.DATA_W(DW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .bus_a(bus_a), .bus_b(bus_b),
      .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_ab(cnt_ab)
   );

   int n_checks = 0, n_fail = 0;
   string cur_req = "R10";
   bit done = 0;

   // behavioural reference model
   int m_val, m_mask, m_en, m_a, m_b, m_ab;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_val = 0; m_mask = (1 << DW) - 1; m_en = 0; m_a = 0; m_b = 0; m_ab = 0;
      end else begin
         bit ha, hb, clr;
         ha  = ((int'(bus_a) ^ m_val) & m_mask) == 0;
         hb  = ((int'(bus_b) ^ m_val) & m_mask) == 0;
         clr = cfg_wr && cfg_addr == 2'd2 && cfg_wdata[1];
         if (clr) begin
            m_a = 0; m_b = 0; m_ab = 0;
         end else if (m_en != 0) begin
            if (ha && m_a < MAXC) m_a++;
            if (hb && m_b < MAXC) m_b++;
            if (ha && hb && m_ab < MAXC) m_ab++;
         end
         if (cfg_wr) begin
            case (cfg_addr)
               2'd0: m_val = int'(cfg_wdata);
               2'd1: m_mask = int'(cfg_wdata);
               2'd2: m_en = int'(cfg_wdata[0]);
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         check(cur_req, "cnt_a", int'(cnt_a), m_a);
         check(cur_req, "cnt_b", int'(cnt_b), m_b);
         check(cur_req, "cnt_ab", int'(cnt_ab), m_ab);
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   function automatic logic [DW-1:0] pick(input logic [DW-1:0] v, input logic [DW-1:0] m);
      int r;
      r = $urandom_range(0, 2);
      if (r == 0) return v;
      if (r == 1) return v ^ (DW'($urandom) & ~m);
      return DW'($urandom);
   endfunction

   initial begin
      int saved_a, saved_b, saved_ab;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R10 reset state and R6 disabled after reset
      check("R10", "cnt_a after reset", int'(cnt_a), 0);
      check("R10", "cnt_ab after reset", int'(cnt_ab), 0);
      cyc(4);
      check("R6", "no count while enable is reset low", int'(cnt_a), 0);

      // R9 value write takes effect one edge later
      cur_req = "R9";
      wr(2'd2, 8'h03);
      bus_a = 8'h3C; bus_b = 8'h00;
      wr(2'd0, 8'h3C);
      check("R9", "cnt_a at value write edge", int'(cnt_a), 0);
      cyc(1);
      check("R9", "cnt_a one edge after write", int'(cnt_a), 1);

      // R1 R2 R3 with a partial mask (R4 don't-care bits)
      cur_req = "R1";
      wr(2'd1, 8'hF0);
      wr(2'd2, 8'h03);
      for (int i = 0; i < 60; i++) begin
         bus_a = pick(8'h3C, 8'hF0);
         bus_b = pick(8'h3C, 8'hF0);
         @(negedge clk);
      end
      cur_req = "R2";
      wr(2'd0, 8'hA5);
      wr(2'd2, 8'h03);
      for (int i = 0; i < 40; i++) begin
         bus_a = pick(8'hA5, 8'hF0);
         bus_b = pick(8'hA5, 8'hF0);
         @(negedge clk);
      end
      check("R3", "joint count bounded", int'(cnt_ab <= cnt_a && cnt_ab <= cnt_b), 1);

      // R4 all-zero mask: every cycle counts
      cur_req = "R4";
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h03);
      for (int i = 0; i < 10; i++) begin
         bus_a = DW'($urandom); bus_b = DW'($urandom);
         @(negedge clk);
      end
      check("R4", "cnt_a with empty mask", int'(cnt_a), 10);
      check("R4", "cnt_ab with empty mask", int'(cnt_ab), 10);

      // R5 held match
      cur_req = "R5";
      wr(2'd1, 8'hFF);
      bus_a = 8'h00; bus_b = 8'h00;
      wr(2'd2, 8'h03);
      bus_a = 8'hA5; bus_b = 8'h5A;
      cyc(7);
      bus_a = 8'h00;
      cyc(1);
      check("R5", "cnt_a after 7 held cycles", int'(cnt_a), 7);
      check("R5", "cnt_b with no match", int'(cnt_b), 0);

      // R6 enable off
      cur_req = "R6";
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      saved_a = int'(cnt_a); saved_b = int'(cnt_b); saved_ab = int'(cnt_ab);
      for (int i = 0; i < 20; i++) begin
         bus_a = DW'($urandom); bus_b = DW'($urandom);
         @(negedge clk);
      end
      check("R6", "cnt_a while disabled", int'(cnt_a), saved_a);
      check("R6", "cnt_b while disabled", int'(cnt_b), saved_b);
      check("R6", "cnt_ab while disabled", int'(cnt_ab), saved_ab);

      // R7 saturation
      cur_req = "R7";
      wr(2'd2, 8'h03);
      cyc(MAXC + 20);
      check("R7", "cnt_a saturated", int'(cnt_a), MAXC);
      check("R7", "cnt_ab saturated", int'(cnt_ab), MAXC);

      // R8 clear wins over a live match
      cur_req = "R8";
      wr(2'd2, 8'h03);
      check("R8", "cnt_a cleared", int'(cnt_a), 0);
      check("R8", "cnt_b cleared", int'(cnt_b), 0);
      check("R8", "cnt_ab cleared", int'(cnt_ab), 0);
      cyc(1);
      check("R8", "count resumes after clear", int'(cnt_ab), 1);

      cyc(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #100000;
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule